// File: doc/BRIEF.md
# Uplink Cyclic Shift Index Generator

This block produces the cyclic shift index applied to a 12-entry base sequence in one symbol of an uplink control transmission. A start pulse captures the request: the sequence identity (a configured hopping identity or the cell identity), the numerology, the slot index, the symbol position and two shift amounts. The block then runs an internal length-31 Gold generator, one bit per clock, to the bit position set by that slot and symbol.

At that position it collects eight pseudo-random bits. The first bit collected becomes the least significant bit of the value. That value is added to the two shift amounts, and the sum is reduced modulo 12.

The result is held on the index output. A one-cycle valid pulse marks it. Callers issue one request per symbol and wait for the pulse.

Top module: `cs_shift_gen`

## Requirements
- R1: When `hop_id_en` is 1, the Gold generator's second register is seeded with `hop_id`. When it is 0, that register is seeded with `cell_id`. Seed bit i goes to register position i, and the upper bits are zero. The first register is seeded with 1 in position 0 and zeros elsewhere.
- R2: The slot index is reduced modulo the number of slots per frame. That number is 10 for `numerology` 0, 20 for 1, 40 for 2, 80 for 3, and 160 for 4 or above.
- R3: The collected bits start at Gold output c(k) with k = (14 × reduced_slot + `sym_l` + `sym_start`) × 8. Here c(n) = x1(n+1600) xor x2(n+1600), with x1(n+31) = x1(n+3) xor x1(n) and x2(n+31) = x2(n+3) xor x2(n+2) xor x2(n+1) xor x2(n).
- R4: The eight bits c(k)..c(k+7) form a value in which c(k+m) has weight 2^m.
- R5: `cs_idx` equals (`cs_init` + `cs_extra` + value) mod 12, and it is always in 0..11 when valid.
- R6: `cs_valid` is high for exactly one cycle per accepted request. `cs_idx` holds its value until the next result.
- R7: `cs_valid` rises 1609 + k clock cycles after the edge that samples `start`.
- R8: A `start` pulse that arrives while a request is in progress has no effect. It produces no extra result and does not alter the pending one.
- R9: Reset drives `cs_valid` to 0 and `cs_idx` to 0, and it abandons any request in progress without producing a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| hop_id_en | input | 1 | Select `hop_id` as the seed |
| hop_id | input | 10 | Configured hopping identity |
| cell_id | input | 10 | Physical cell identity |
| numerology | input | 3 | Subcarrier spacing configuration |
| slot_idx | input | 8 | Slot index before reduction |
| sym_l | input | 4 | Symbol index within the transmission |
| sym_start | input | 4 | First symbol of the transmission |
| cs_init | input | 4 | Initial cyclic shift |
| cs_extra | input | 4 | Additional shift offset |
| cs_valid | output | 1 | One-cycle result strobe |
| cs_idx | output | 4 | Cyclic shift index 0..11 |

## Verification
On every cycle, the checker confirms four things: the index stays in range whenever it is valid, the valid strobe lasts one cycle, the index holds between results, and each request ends with a valid strobe at the moment the block leaves its busy state.

Some behaviours can only be shown by the bench's scenarios, where results are compared against a reference Gold sequence:
- the seed selection;
- the slot reduction for each numerology;
- the bit position and the bit ordering;
- the wrap of the shift sum;
- the exact latency;
- that an overlapping start or a mid-run reset leaves no stray result.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ID_W      = 10;
  localparam int SLOT_W    = 8;
  localparam int SYM_W     = 4;
  localparam int SHIFT_W   = 4;
  localparam int NCS_BITS  = 8;
  localparam int N_SHIFTS  = 12;
  localparam int SYM_SLOT  = 14;
  localparam int WARMUP    = 1600;
  localparam int LFSR_LEN  = 31;
  localparam int CNT_W     = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_GATHER = 2'd2
  } cs_state_e;
endpackage

// File: rtl/cs_lfsr.sv
module cs_lfsr #(
  parameter int                LEN  = 31,
  parameter logic [LEN-1:0]    TAPS = 31'h9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [LEN-1:0] seed,
  output logic           head
);
  logic [LEN-1:0] s_q, s_d;
  logic           fb;

  assign fb   = ^(s_q & TAPS);
  assign head = s_q[0];

  always_comb begin
    s_d = s_q;
    if (load)      s_d = seed;
    else if (step) s_d = {fb, s_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else if (load || step) s_q <= s_d;
  end
endmodule

// File: rtl/cs_gold_gen.sv
module cs_gold_gen
  import cs_pkg::*;
#(
  parameter int SEED_W = ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [SEED_W-1:0] seed,
  output logic              bit_out
);
  localparam logic [LFSR_LEN-1:0] X1_TAPS = LFSR_LEN'(32'h0000_0009);
  localparam logic [LFSR_LEN-1:0] X2_TAPS = LFSR_LEN'(32'h0000_000F);
  localparam logic [LFSR_LEN-1:0] X1_INIT = LFSR_LEN'(32'h0000_0001);

  logic h1, h2;
  logic [LFSR_LEN-1:0] x2_init;

  assign x2_init = LFSR_LEN'(seed);

  cs_lfsr #(.LEN(LFSR_LEN), .TAPS(X1_TAPS)) u_x1 (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .seed(X1_INIT), .head(h1)
  );
  cs_lfsr #(.LEN(LFSR_LEN), .TAPS(X2_TAPS)) u_x2 (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .seed(x2_init), .head(h2)
  );

  assign bit_out = h1 ^ h2;
endmodule

// File: rtl/cs_pos_calc.sv
module cs_pos_calc
  import cs_pkg::*;
(
  input  logic [2:0]        numerology,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [SYM_W-1:0]  sym_l,
  input  logic [SYM_W-1:0]  sym_start,
  output logic [CNT_W-1:0]  steps
);
  logic [SLOT_W-1:0] slot_red;
  logic [CNT_W-1:0]  sym_pos;

  always_comb begin
    unique case (numerology)
      3'd0:    slot_red = SLOT_W'(slot_idx % SLOT_W'(10));
      3'd1:    slot_red = SLOT_W'(slot_idx % SLOT_W'(20));
      3'd2:    slot_red = SLOT_W'(slot_idx % SLOT_W'(40));
      3'd3:    slot_red = SLOT_W'(slot_idx % SLOT_W'(80));
      default: slot_red = SLOT_W'(slot_idx % SLOT_W'(160));
    endcase
  end

  assign sym_pos = CNT_W'(SYM_SLOT) * CNT_W'(slot_red) + CNT_W'(sym_l) + CNT_W'(sym_start);
  assign steps   = CNT_W'(WARMUP) + sym_pos * CNT_W'(NCS_BITS);
endmodule

// File: rtl/cs_mod_combine.sv
module cs_mod_combine
  import cs_pkg::*;
(
  input  logic [SHIFT_W:0]    shift_sum,
  input  logic [NCS_BITS-1:0] ncs,
  output logic [SHIFT_W-1:0]  idx
);
  localparam int SUM_W = NCS_BITS + 2;
  logic [SUM_W-1:0] total;

  assign total = SUM_W'(shift_sum) + SUM_W'(ncs);
  assign idx   = SHIFT_W'(total % SUM_W'(N_SHIFTS));
endmodule

// File: rtl/cs_shift_gen.sv
module cs_shift_gen
  import cs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               hop_id_en,
  input  logic [ID_W-1:0]    hop_id,
  input  logic [ID_W-1:0]    cell_id,
  input  logic [2:0]         numerology,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic [SYM_W-1:0]   sym_l,
  input  logic [SYM_W-1:0]   sym_start,
  input  logic [SHIFT_W-1:0] cs_init,
  input  logic [SHIFT_W-1:0] cs_extra,
  output logic               cs_valid,
  output logic [SHIFT_W-1:0] cs_idx
);
  localparam int BIT_W = $clog2(NCS_BITS);

  cs_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BIT_W-1:0]    bpos_q, bpos_d;
  logic [NCS_BITS-1:0] acc_q, acc_d;
  logic [SHIFT_W:0]    ssum_q, ssum_d;
  logic                valid_d;
  logic [SHIFT_W-1:0]  idx_d;
  logic                busy;

  logic                accept, load, step, gold_bit, last_bit;
  logic [CNT_W-1:0]    steps;
  logic [ID_W-1:0]     seed;
  logic [NCS_BITS-1:0] ncs_final;
  logic [SHIFT_W-1:0]  idx_calc;

  assign busy      = (state_q != ST_IDLE);
  assign accept    = start && (state_q == ST_IDLE);
  assign seed      = hop_id_en ? hop_id : cell_id;
  assign load      = accept;
  assign step      = ((state_q == ST_RUN) && (cnt_q != '0)) || (state_q == ST_GATHER);
  assign last_bit  = (state_q == ST_GATHER) && (bpos_q == BIT_W'(NCS_BITS - 1));
  assign ncs_final = {gold_bit, acc_q[NCS_BITS-1:1]};

  cs_pos_calc u_pos (
    .numerology(numerology), .slot_idx(slot_idx), .sym_l(sym_l),
    .sym_start(sym_start), .steps(steps)
  );

  cs_gold_gen #(.SEED_W(ID_W)) u_gold (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .seed(seed), .bit_out(gold_bit)
  );

  cs_mod_combine u_comb (
    .shift_sum(ssum_q), .ncs(ncs_final), .idx(idx_calc)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bpos_d  = bpos_q;
    acc_d   = acc_q;
    ssum_d  = ssum_q;
    valid_d = 1'b0;
    idx_d   = cs_idx;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = steps;
          ssum_d  = {1'b0, cs_init} + {1'b0, cs_extra};
        end
      end
      ST_RUN: begin
        if (cnt_q == '0) begin
          state_d = ST_GATHER;
          bpos_d  = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_GATHER: begin
        acc_d  = ncs_final;
        bpos_d = bpos_q + 1'b1;
        if (last_bit) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
          idx_d   = idx_calc;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bpos_q   <= '0;
      acc_q    <= '0;
      ssum_q   <= '0;
      cs_valid <= 1'b0;
      cs_idx   <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      bpos_q   <= bpos_d;
      acc_q    <= acc_d;
      ssum_q   <= ssum_d;
      cs_valid <= valid_d;
      cs_idx   <= idx_d;
    end
  end
endmodule

// File: rtl/cs_shift_gen_chk.sv
module cs_shift_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid,
  input logic [3:0] idx,
  input logic       busy
);
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (idx < 4'd12));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(idx));

  p_done_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid);

  p_valid_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !busy);
endmodule

bind cs_shift_gen cs_shift_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid(cs_valid), .idx(cs_idx), .busy(busy)
);

// File: tb/tb_cs_shift_gen.sv
module tb_cs_shift_gen;
  localparam int MAXN = 20100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       hop_id_en = 1'b0;
  logic [9:0] hop_id = '0;
  logic [9:0] cell_id = '0;
  logic [2:0] numerology = '0;
  logic [7:0] slot_idx = '0;
  logic [3:0] sym_l = '0;
  logic [3:0] sym_start = '0;
  logic [3:0] cs_init = '0;
  logic [3:0] cs_extra = '0;
  logic       cs_valid;
  logic [3:0] cs_idx;

  always #4 clk = ~clk;

  cs_shift_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hop_id_en(hop_id_en), .hop_id(hop_id),
    .cell_id(cell_id), .numerology(numerology), .slot_idx(slot_idx), .sym_l(sym_l),
    .sym_start(sym_start), .cs_init(cs_init), .cs_extra(cs_extra),
    .cs_valid(cs_valid), .cs_idx(cs_idx)
  );

  typedef struct {
    int     exp_idx;
    longint exp_cyc;
    string  req;
  } item_t;

  item_t  sbq[$];
  longint cyc = 0;
  int     n_run = 0;
  int     n_fail = 0;
  int     stray = 0;
  bit     ended = 0;
  bit     x1r [0:MAXN];
  bit     x2r [0:MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int slots_per_frame(input int mu);
    if (mu >= 4) return 160;
    return 10 << mu;
  endfunction

  function automatic int bit_pos(input int mu, input int slot, input int l, input int ls);
    return (14 * (slot % slots_per_frame(mu)) + l + ls) * 8;
  endfunction

  // Reference Gold sequence built from its recurrences (R1, R3), bits LSB-first (R4)
  function automatic int ref_ncs(input int seed, input int k);
    int v;
    for (int i = 0; i < 31; i++) begin
      x1r[i] = (i == 0);
      x2r[i] = (i < 10) ? seed[i] : 1'b0;
    end
    for (int n = 0; n + 31 <= 1600 + k + 8; n++) begin
      x1r[n+31] = x1r[n+3] ^ x1r[n];
      x2r[n+31] = x2r[n+3] ^ x2r[n+2] ^ x2r[n+1] ^ x2r[n];
    end
    v = 0;
    for (int m = 0; m < 8; m++)
      v += int'(x1r[1600+k+m] ^ x2r[1600+k+m]) << m;
    return v;
  endfunction

  task automatic drive(input bit hv, input int hid, input int cid, input int mu, input int slot,
                       input int l, input int ls, input int ci, input int ce);
    hop_id_en  = hv;
    hop_id     = 10'(hid);
    cell_id    = 10'(cid);
    numerology = 3'(mu);
    slot_idx   = 8'(slot);
    sym_l      = 4'(l);
    sym_start  = 4'(ls);
    cs_init    = 4'(ci);
    cs_extra   = 4'(ce);
  endtask

  // Driver: pushes the expected item then pulses start; optional overlapping start (R8)
  task automatic request(input bit hv, input int hid, input int cid, input int mu, input int slot,
                         input int l, input int ls, input int ci, input int ce,
                         input string req, input bit overlap);
    item_t it;
    int k;
    k = bit_pos(mu, slot, l, ls);
    it.exp_idx = (ci + ce + ref_ncs(hv ? hid : cid, k)) % 12;
    @(negedge clk);
    it.exp_cyc = cyc + 1609 + k + 1;
    it.req = req;
    sbq.push_back(it);
    drive(hv, hid, cid, mu, slot, l, ls, ci, ce);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (overlap) begin
      repeat (20) @(negedge clk);
      drive(!hv, hid ^ 10'h155, cid ^ 10'h2AA, 0, 3, 5, 2, 7, 9);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(cs_valid == 1'b0, {req, " R6 pulse"}, cs_valid, 0);
    chk(cs_idx == 4'(it.exp_idx), {req, " R6 hold"}, cs_idx, it.exp_idx);
  endtask

  // Monitor: compares each result with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && cs_valid) begin
      if (sbq.size() == 0) begin
        stray++;
        chk(1'b0, "R8 unexpected result", cs_idx, -1);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(cs_idx == 4'(it.exp_idx), {it.req, " R5 index"}, cs_idx, it.exp_idx);
        chk(cyc == it.exp_cyc, {it.req, " R7 latency"}, cyc, it.exp_cyc);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_valid == 1'b0, "R9 reset valid", cs_valid, 0);
    chk(cs_idx == 4'd0, "R9 reset idx", cs_idx, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 cell identity seed, R3 base position, R4 ordering
    request(0, 0, 1, 0, 0, 0, 0, 0, 0, "R1 cell seed", 0);
    request(0, 0, 501, 0, 2, 3, 1, 0, 0, "R3 cell 501", 0);
    // R1 hopping identity overrides cell identity
    request(1, 777, 501, 0, 2, 3, 1, 0, 0, "R1 hop seed", 0);
    // R2 slot reduction per numerology
    request(0, 0, 33, 0, 13, 0, 0, 0, 0, "R2 mu0 slot13", 0);
    request(0, 0, 33, 1, 25, 1, 0, 2, 1, "R2 mu1 slot25", 0);
    request(0, 0, 33, 4, 165, 0, 0, 0, 0, "R2 mu4 slot165", 0);
    request(1, 1023, 0, 7, 164, 4, 6, 1, 1, "R2 mu7 slot164", 0);
    // R3 large offset
    request(0, 0, 1000, 4, 159, 13, 13, 3, 4, "R3 max offset", 0);
    // R5 shift wrap
    request(0, 0, 77, 2, 7, 9, 2, 11, 11, "R5 wrap", 0);
    request(1, 5, 0, 3, 50, 0, 0, 15, 15, "R5 max shifts", 0);
    // R8 overlapping start ignored
    request(0, 0, 200, 0, 4, 6, 0, 5, 6, "R8 overlap", 1);
    repeat (2500) @(negedge clk);
    chk(stray == 0, "R8 no extra result", stray, 0);

    // R9 reset mid-run abandons the request
    drive(0, 0, 12, 0, 1, 0, 0, 1, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_valid == 1'b0, "R9 mid-run valid", cs_valid, 0);
    chk(cs_idx == 4'd0, "R9 mid-run idx", cs_idx, 0);
    rst_n = 1'b1;
    repeat (2500) @(negedge clk);
    chk(stray == 0, "R9 no result after reset", stray, 0);
    chk(cs_idx == 4'd0, "R9 idx stays cleared", cs_idx, 0);

    finish_run();
  end
endmodule